// File: doc/BRIEF.md
# Pin I/O Controller with Level and Edge Interrupts

This block controls a bank of general-purpose pins. Software picks each pin's direction. For an output pin it sets the value driven onto the pad. For any pin it reads back the pad state after a synchroniser. Every pin can also request an interrupt. All enabled requests are ORed onto one interrupt line.

Each pin's interrupt works in one of two modes. In level mode the raw pad input reaches the interrupt line through gates only, with no clocked stage. A pulse of any width therefore shows on the line for as long as it lasts. In edge mode the pad passes a two-flop synchroniser and then one delay flop. A transition between the last two copies sets a sticky status bit, which software clears by writing a one to it. An edge-mode pulse must span a sampling edge of the module clock, with setup and hold met, to be seen. Shorter pulses are lost.

The register bus is a single-cycle write port with a combinational read port. Both share one address. The register map is:

| Address | Register | Access |
|---|---|---|
| 0 | Direction | read/write |
| 1 | Output value | read/write |
| 2 | Synchronised input | read-only |
| 3 | Interrupt enable | read/write |
| 4 | Interrupt type | read/write |
| 5 | Polarity | read/write |
| 6 | Edge status | write-1-to-clear |
| 7 | Unused | reads 0 |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register is 0, so `pad_oe_o`, `pad_o` and `irq_o` are 0 and all readback values are 0.
- R2: The direction register (address 0, bit n = 1 makes pin n an output) drives `pad_oe_o` from the clock edge that writes it. Registers at addresses 0, 1, 3, 4 and 5 read back the last value written.
- R3: The output register (address 1) drives `pad_o` from the clock edge that writes it.
- R4: Address 2 reads `pad_i` as sampled two clock edges earlier. Writes to address 2 change nothing.
- R5: A pin with type bit 0 (address 4) is in level mode. Its request equals `pad_i` when its polarity bit (address 5) is 1, and the inverse of `pad_i` when the bit is 0. The request follows the pad with no clock edge in between.
- R6: A pin with type bit 1 is in edge mode. Polarity 1 selects rising edges and polarity 0 selects falling edges. A selected transition on `pad_i` sets that pin's status bit (address 6) at the third clock edge after the change, whether or not the pin's interrupt is enabled.
- R7: A status bit stays set until a write to address 6 has a 1 in its position. Zero bits in that write leave status unchanged. A new edge event at the same clock edge as the clear wins.
- R8: `irq_o` is the OR over all pins of the interrupt-enable bit (address 3) ANDed with the pin request. The request is the status bit for an edge-mode pin and the level request for a level-mode pin.
- R9: A pad pulse that starts and ends between two clock edges sets no status bit in edge mode. In level mode the same pulse drives `irq_o` while it lasts.
- R10: Pins in level mode never set status bits. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr_i | input | 3 | Register address for reads and writes |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Read data for `bus_addr_i`, combinational |
| pad_i | input | N_PINS | Pad input values |
| pad_o | output | N_PINS | Pad output values |
| pad_oe_o | output | N_PINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The synchroniser check assumes `pad_i` is held low while reset is asserted. That way the flops' reset value matches the pad history that the property looks back on. The bench drives the pads to zero throughout reset, and changes pads and bus inputs only away from the rising edge. The only exception is one short pulse placed wholly inside a clock period, which deliberately exercises the missed-pulse case. The assertions also assume that a write to the status address is the only way status bits fall, so no other bus address is ever decoded as a clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] ADR_DIR  = 3'd0;
  localparam logic [AW-1:0] ADR_OUT  = 3'd1;
  localparam logic [AW-1:0] ADR_IN   = 3'd2;
  localparam logic [AW-1:0] ADR_IE   = 3'd3;
  localparam logic [AW-1:0] ADR_TYPE = 3'd4;
  localparam logic [AW-1:0] ADR_POL  = 3'd5;
  localparam logic [AW-1:0] ADR_STAT = 3'd6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] rise_sel_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= sync_i;
  end

  // polarity 1: rising, 0: falling
  assign evt_o = (rise_sel_i & sync_i & ~dly_q) | (~rise_sel_i & ~sync_i & dly_q);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] in_sync_i,
  input  logic [WIDTH-1:0] edge_evt_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] ie_o,
  output logic [WIDTH-1:0] type_o,
  output logic [WIDTH-1:0] pol_o,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] dir_q, out_q, ie_q, type_q, pol_q, status_q;
  logic [WIDTH-1:0] clr_mask;

  assign clr_mask = (we_i && addr_i == ADR_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      out_q    <= '0;
      ie_q     <= '0;
      type_q   <= '0;
      pol_q    <= '0;
      status_q <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          ADR_DIR:  dir_q  <= wdata_i;
          ADR_OUT:  out_q  <= wdata_i;
          ADR_IE:   ie_q   <= wdata_i;
          ADR_TYPE: type_q <= wdata_i;
          ADR_POL:  pol_q  <= wdata_i;
          default:  ;
        endcase
      end
      // set beats clear
      status_q <= (status_q & ~clr_mask) | (edge_evt_i & type_q);
    end
  end

  always_comb begin
    case (addr_i)
      ADR_DIR:  rdata_o = dir_q;
      ADR_OUT:  rdata_o = out_q;
      ADR_IN:   rdata_o = in_sync_i;
      ADR_IE:   rdata_o = ie_q;
      ADR_TYPE: rdata_o = type_q;
      ADR_POL:  rdata_o = pol_q;
      ADR_STAT: rdata_o = status_q;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign ie_o     = ie_q;
  assign type_o   = type_q;
  assign pol_o    = pol_q;
  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] in_sync, edge_evt;
  logic [N_PINS-1:0] dir_q, out_q, ie_q, type_q, pol_q, status_q;
  logic [N_PINS-1:0] pin_req;

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (in_sync)
  );

  gpio_edge_det #(.WIDTH(N_PINS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (in_sync),
    .rise_sel_i (pol_q),
    .evt_o      (edge_evt)
  );

  gpio_regs #(.WIDTH(N_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .in_sync_i  (in_sync),
    .edge_evt_i (edge_evt),
    .dir_o      (dir_q),
    .out_o      (out_q),
    .ie_o       (ie_q),
    .type_o     (type_q),
    .pol_o      (pol_q),
    .status_o   (status_q)
  );

  // level pins take the raw pad, no clock
  for (genvar p = 0; p < N_PINS; p++) begin : g_req
    assign pin_req[p] = type_q[p] ? status_q[p] : ~(pad_i[p] ^ pol_q[p]);
  end

  assign irq_o    = |(ie_q & pin_req);
  assign pad_o    = out_q;
  assign pad_oe_o = dir_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] rdata_i,
  input logic [N_PINS-1:0] pad_i,
  input logic [N_PINS-1:0] pad_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] ie_i,
  input logic [N_PINS-1:0] type_i,
  input logic [N_PINS-1:0] status_i
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r2_oe_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_DIR) |=> pad_oe_o == $past(wdata_i));

  a_r3_out_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_OUT) |=> pad_o == $past(wdata_i));

  a_r4_in_two_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && addr_i == ADR_IN) |-> rdata_i == $past(pad_i, 2));

  a_r7_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADR_STAT) |=> (status_i & $past(status_i)) == $past(status_i));

  a_r10_level_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_i & ~$past(status_i) & ~$past(type_i)) == '0);

  a_r8_no_enable_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_i == '0) |-> !irq_o);

  a_r10_unused_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd7) |-> rdata_i == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (bus_we_i),
  .addr_i   (bus_addr_i),
  .wdata_i  (bus_wdata_i),
  .rdata_i  (bus_rdata_o),
  .pad_i    (pad_i),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .ie_i     (ie_q),
  .type_i   (type_q),
  .status_i (status_q)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  localparam int N = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         we = 0;
  logic [2:0]   addr = 0;
  logic [N-1:0] wdata = 0;
  logic [N-1:0] rdata;
  logic [N-1:0] pad_in = 0;
  logic [N-1:0] pad_out, pad_oe;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int rd_ptr = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // behavioural model
  logic [N-1:0] m_dir = 0, m_out = 0, m_ie = 0, m_type = 0, m_pol = 0, m_stat = 0;
  logic [N-1:0] hist [$] = '{'0, '0, '0};  // hist[0] = newest edge sample

  always @(posedge clk) begin
    if (rst_n) begin
      logic [N-1:0] a, b, evt;
      a = hist[1]; b = hist[2];
      evt = m_type & ((m_pol & a & ~b) | (~m_pol & ~a & b));
      if (we && addr == 3'd6) m_stat = m_stat & ~wdata;
      m_stat = m_stat | evt;
      if (we) begin
        case (addr)
          3'd0: m_dir  = wdata;
          3'd1: m_out  = wdata;
          3'd3: m_ie   = wdata;
          3'd4: m_type = wdata;
          3'd5: m_pol  = wdata;
          default: ;
        endcase
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [N-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_out;
      3'd2: return hist[1];
      3'd3: return m_ie;
      3'd4: return m_type;
      3'd5: return m_pol;
      3'd6: return m_stat;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic [N-1:0] req;
    req = (m_type & m_stat) | (~m_type & ~(pad_in ^ m_pol));
    return |(m_ie & req);
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after stimulus at negedge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      case (addr)
        3'd2:    chk("R4 in readback", rdata, exp_rd(addr));
        3'd6:    chk("R6 R7 status readback", rdata, exp_rd(addr));
        3'd7:    chk("R10 unused addr", rdata, exp_rd(addr));
        default: chk("R2 reg readback", rdata, exp_rd(addr));
      endcase
      chk("R2 pad_oe", pad_oe, m_dir);
      chk("R3 pad_o", pad_out, m_out);
      chk("R8 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_irq()});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 0; addr = 3'(rd_ptr); rd_ptr++;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; addr = 3'(rd_ptr); rd_ptr++;
  endtask

  task automatic set_pad(input logic [N-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk("R1 pad_oe at reset", pad_oe, '0);
    chk("R1 pad_o at reset", pad_out, '0);
    chk("R1 irq at reset", {{(N-1){1'b0}}, irq}, '0);
    chk("R1 rdata at reset", rdata, '0);
    @(negedge clk); rst_n = 1;
    idle(8);

    wr(3'd0, 8'h0F);
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'hFF);  // R4 ignored write
    set_pad(8'h3C); idle(8);
    set_pad(8'hC3); idle(8);
    set_pad(8'h00); idle(4);

    // pins 0-3 level (0,1 active high), 4-7 edge (4,6 rising)
    wr(3'd5, 8'h53);
    wr(3'd4, 8'hF0);
    wr(3'd6, 8'hFF);
    idle(4);
    set_pad(8'hF0); idle(6);   // R6 rises on 4,6, status set without enable
    set_pad(8'h00); idle(6);   // falls on 5,7
    wr(3'd3, 8'hFF); idle(4);
    wr(3'd6, 8'h00); idle(2);  // R7 zero write keeps bits
    wr(3'd6, 8'h50); idle(2);
    wr(3'd3, 8'h30); idle(4);
    wr(3'd6, 8'hFF); idle(4);

    // R7 clear coinciding with new events
    set_pad(8'h50);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); we = 1; addr = 3'd6; wdata = 8'hFF;
    end
    idle(4);
    wr(3'd6, 8'hFF);

    // R9 narrow pulse on pin 0 (level) and pin 4 (edge), no edge inside
    wr(3'd6, 8'hFF);
    set_pad(8'h00); idle(4);
    wr(3'd5, 8'h53);
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h01); idle(3);
    @(negedge clk); we = 0; addr = 3'd6;
    #3 pad_in = 8'h11;
    #2;
    chk("R9 level irq during short pulse", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, 1'b1});
    chk("R5 level follows pad without clock", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_irq()});
    #2 pad_in = 8'h00;
    #1;
    chk("R9 level irq after pulse", {{(N-1){1'b0}}, irq}, '0);
    idle(5);
    @(negedge clk); we = 0; addr = 3'd6; #2;
    chk("R9 no status from short pulse", rdata, 8'h00);

    // R10 level pins toggled never set status
    wr(3'd4, 8'h00);
    set_pad(8'hFF); idle(5);
    set_pad(8'h00); idle(5);
    @(negedge clk); we = 0; addr = 3'd6; #2;
    chk("R10 no status in level mode", rdata, 8'h00);
    idle(16);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule